// File: doc/BRIEF.md
# SPI Master Exchange Engine

This block is a serial-peripheral-interface master. Software-side logic fills a transmit queue with 16-bit words through a valid/ready stream, then sets a self-clearing exchange bit in the control word. The engine then sends every queued word, one after another. From each word it sends only the low n bits, most significant bit of that field first. While it sends, it captures the same number of bits from the serial input. Each captured word goes into a receive queue, right-justified, and a second valid/ready stream hands those words out.

The control word sets the enable, the exchange trigger, the select polarity, a pulse-between-words select waveform, clock phase and polarity, the word length, the clock divider and an optional ready gate. When the ready gate is on, an active-low ready input holds off each word. Clearing the enable empties both queues and returns the engine to idle. While the enable is set, every field except the exchange trigger is locked.

Top module: `spi_xchg_master`

## Requirements
- R1: A control write with bit 0 (enable) at 0 empties both queues, stops any transfer, clears busy and drives the select inactive on the following cycle.
- R2: While enable is 1, a control write that keeps enable at 1 changes no field other than bit 1 (exchange). The readback on `cfg_rdata` shows the earlier fields.
- R3: With enable already 1, writing bit 1 as 1 sets `busy` from the next cycle. A write that turns enable on from 0 does not start an exchange.
- R4: `busy` clears by itself after the last bit of the last queued word. If the transmit queue is empty when the exchange starts, `busy` clears within three cycles and no clock edge is produced.
- R5: Field bits 9:6 (len) give n = len+1 bits per word (0 gives 1 bit, 15 gives 16 bits). The engine sends bits n-1 down to 0 of each transmit word on `mosi`, high bit first.
- R6: Each finished word is pushed to the receive queue with the received bits right-justified and the upper bits zero. When the 8-entry receive queue is full, the word is dropped.
- R7: Bit 2 selects the select polarity: 1 means active high, 0 means active low. When not busy, `ss` is at the inactive level.
- R8: With bit 3 set to 1, the select goes inactive for one half clock period between words. With bit 3 at 0, it stays active across the whole exchange.
- R9: Bit 5 sets the idle level of `sclk`. With bit 4 (phase) at 0, `miso` is sampled on the first edge of each bit. With bit 4 at 1, it is sampled on the second edge.
- R10: Bits 12:10 (k) set the half period of `sclk` to 2^k system clocks.
- R11: With bit 13 (ready gate) at 1, no word starts while `rdy_n` is high. The clock stays idle and the select stays inactive until `rdy_n` goes low.
- R12: A transmit word is accepted when `tx_valid` and `tx_ready` are both high, and `tx_ready` is low when the 8-entry queue is full. `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | control word write strobe |
| cfg_wdata | input | 14 | control word write value |
| cfg_rdata | output | 14 | control word readback |
| busy | output | 1 | exchange bit readback |
| tx_valid | input | 1 | transmit word offered |
| tx_ready | output | 1 | transmit queue has room |
| tx_data | input | 16 | transmit word |
| rx_valid | output | 1 | received word available |
| rx_ready | input | 1 | consumer takes the received word |
| rx_data | output | 16 | received word |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| ss | output | 1 | slave select |
| rdy_n | input | 1 | active-low slave ready |

## Verification
The assertions rely on three things about the inputs. Control writes are only presented after reset is released. `miso` and `rdy_n` are synchronous to the system clock. A consumer that leaves `rx_ready` low lets the receive word wait, rather than expecting it to be replaced. The bench drives every input a short delay after the rising clock edge. It loops `mosi` back onto `miso`, so received data is always settled at the sampling edge. It changes the mode fields only through a disabling write, so the locking rule is never in conflict with the checks that watch `cfg_rdata`.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 4;
  localparam int DIV_W  = 3;
  localparam int CFG_W  = 14;

  localparam int B_EN    = 0;
  localparam int B_GO    = 1;
  localparam int B_SPOL  = 2;
  localparam int B_PULSE = 3;
  localparam int B_CPHA  = 4;
  localparam int B_CPOL  = 5;

  typedef struct packed {
    logic             gate;
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] len;
    logic             cpol;
    logic             cpha;
    logic             pulse;
    logic             spol;
    logic             go;
    logic             en;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } eng_state_t;
endpackage

// File: rtl/spi_xchg_fifo.sv
module spi_xchg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push, pop;

  assign in_ready  = (cnt != (AW+1)'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= in_data;
        wp      <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_xchg_div.sv
module spi_xchg_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = (CNT_W'(1) << sel) - CNT_W'(1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_xchg_eng.sv
module spi_xchg_eng
  import spi_xchg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              go,
  input  logic              spol,
  input  logic              pulse,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              gate,
  input  logic [LEN_W-1:0]  len,
  input  logic              tick,
  output logic              run,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  input  logic              miso,
  input  logic              rdy_n,
  output logic              sclk,
  output logic              mosi,
  output logic              ss
);
  eng_state_t        st;
  logic              ph;
  logic              sel_act;
  logic [LEN_W-1:0]  left;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] rxsh;
  logic              start_ok;
  logic              last_edge;

  assign start_ok  = tx_valid && (!gate || !rdy_n);
  assign last_edge = (st == ST_XFER) && tick && ph && (left == '0);
  assign tx_pop    = (st == ST_WAIT) && start_ok;
  assign rx_push   = last_edge;
  assign rx_word   = rxsh;
  assign done      = ((st == ST_WAIT) && !tx_valid) || (last_edge && !tx_valid);
  assign run       = (st == ST_XFER) || (st == ST_GAP);
  assign sclk      = cpol ^ ((st == ST_XFER) && (ph ^ cpha));
  assign mosi      = shreg[WORD_W-1];
  assign ss        = spol ? sel_act : !sel_act;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      st      <= ST_IDLE;
      ph      <= 1'b0;
      sel_act <= 1'b0;
      left    <= '0;
      shreg   <= '0;
      rxsh    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (go) st <= ST_WAIT;
        ST_WAIT: begin
          if (!tx_valid) begin
            st      <= ST_IDLE;
            sel_act <= 1'b0;
          end else if (start_ok) begin
            st      <= ST_XFER;
            ph      <= 1'b0;
            sel_act <= 1'b1;
            left    <= len;
            shreg   <= tx_word << (4'd15 - len);
            rxsh    <= '0;
          end
        end
        ST_XFER: if (tick) begin
          if (!ph) begin
            ph   <= 1'b1;
            rxsh <= {rxsh[WORD_W-2:0], miso};
          end else if (left == '0) begin
            if (!tx_valid) begin
              st      <= ST_IDLE;
              sel_act <= 1'b0;
            end else if (pulse) begin
              st      <= ST_GAP;
              sel_act <= 1'b0;
            end else begin
              st <= ST_WAIT;
            end
          end else begin
            left  <= left - 1'b1;
            shreg <= shreg << 1;
            ph    <= 1'b0;
          end
        end
        ST_GAP: if (tick) st <= ST_WAIT;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xchg_master.sv
module spi_xchg_master
  import spi_xchg_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              busy,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss,
  input  logic              rdy_n
);
  cfg_t              cfg;
  cfg_t              wd;
  logic              flush;
  logic              done;
  logic              tick, run;
  logic              q_valid, q_pop;
  logic [WORD_W-1:0] q_word;
  logic              rx_push, rx_space;
  logic [WORD_W-1:0] rx_word;

  assign wd        = cfg_t'(cfg_wdata);
  assign flush     = cfg_we && !wd.en;
  assign cfg_rdata = cfg;
  assign busy      = cfg.go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_we && (!wd.en || !cfg.en)) begin
      cfg    <= wd;
      cfg.go <= 1'b0;
    end else if (cfg_we && wd.go && !cfg.go) begin
      cfg.go <= 1'b1;
    end else if (done) begin
      cfg.go <= 1'b0;
    end
  end

  spi_xchg_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(q_valid), .out_ready(q_pop), .out_data(q_word)
  );

  spi_xchg_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(rx_push), .in_ready(rx_space), .in_data(rx_word),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  spi_xchg_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(cfg.div), .tick(tick)
  );

  spi_xchg_eng u_eng (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .go(cfg.go), .spol(cfg.spol), .pulse(cfg.pulse), .cpha(cfg.cpha),
    .cpol(cfg.cpol), .gate(cfg.gate), .len(cfg.len),
    .tick(tick), .run(run),
    .tx_valid(q_valid), .tx_word(q_word), .tx_pop(q_pop),
    .rx_push(rx_push), .rx_word(rx_word), .done(done),
    .miso(miso), .rdy_n(rdy_n), .sclk(sclk), .mosi(mosi), .ss(ss)
  );
endmodule

// File: rtl/spi_xchg_chk.sv
module spi_xchg_chk
  import spi_xchg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic              busy,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sclk,
  input logic              ss,
  input logic              flush,
  input logic              rx_push,
  input logic              rx_space
);
  localparam logic [CFG_W-1:0] GO_MASK = CFG_W'(1) << B_GO;

  // R9: clock rests at its idle level outside an exchange
  p_idle_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cfg_rdata[B_CPOL]);

  // R7: select inactive outside an exchange
  p_idle_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ss == !cfg_rdata[B_SPOL]);

  // R2: fields other than the exchange bit hold while enabled
  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[B_EN] && $past(cfg_rdata[B_EN]))
      |-> ((cfg_rdata & ~GO_MASK) == ($past(cfg_rdata) & ~GO_MASK)));

  // R1: disabling write leaves the block idle and empty
  p_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && !cfg_wdata[B_EN]) |-> (!busy && tx_ready && !rx_valid));

  // R12: held receive word stays put
  p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !flush) |=> (rx_valid && $stable(rx_data)));

  // R6: a word arriving at a full receive queue is dropped, the queue stays full
  p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_space && !rx_ready && !flush) |=> !rx_space);
endmodule

bind spi_xchg_master spi_xchg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .busy(busy), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .sclk(sclk), .ss(ss), .flush(flush), .rx_push(rx_push),
  .rx_space(rx_space)
);

// File: tb/spi_xchg_master_test.sv
module spi_xchg_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [13:0] cfg_wdata = '0;
  logic [13:0] cfg_rdata;
  logic        busy;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [15:0] rx_data;
  logic        sclk, mosi, miso, ss;
  logic        rdy_n = 1'b1;

  int tests = 0;
  int fails = 0;

  logic       b_spol = 0, b_pulse = 0, b_cpha = 0, b_cpol = 0, b_gate = 0;
  logic [3:0] b_len = 0;
  logic [2:0] b_div = 0;

  logic [15:0] mosi_q[$];
  logic [15:0] rx_q[$];
  bit          mon_on = 0;
  int          edges = 0, ss_offs = 0, nb = 0;
  time         t_prev = 0, gap = 0;
  logic [15:0] acc = 0;

  always #4 clk = ~clk;
  assign miso = mosi;

  spi_xchg_master uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [13:0] cfgword(input logic en, input logic go);
    return {b_gate, b_div, b_len, b_cpol, b_cpha, b_pulse, b_spol, go, en};
  endfunction

  function automatic logic [15:0] lowmask(input logic [3:0] len);
    return 16'((32'd1 << (len + 1)) - 1);
  endfunction

  task automatic wr(input logic [13:0] v);
    step();
    cfg_we = 1'b1;
    cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic mode(input logic spol, pulse, cpha, cpol, gate,
                      input logic [3:0] len, input logic [2:0] dv);
    b_spol = spol; b_pulse = pulse; b_cpha = cpha; b_cpol = cpol;
    b_gate = gate; b_len = len; b_div = dv;
    wr(cfgword(1'b0, 1'b0));
    wr(cfgword(1'b1, 1'b0));
  endtask

  task automatic push(input logic [15:0] d, input bit exp_tx, input bit exp_rx);
    step();
    while (!tx_ready) step();
    tx_valid = 1'b1;
    tx_data = d;
    if (exp_tx) mosi_q.push_back(d & lowmask(b_len));
    if (exp_rx) rx_q.push_back(d & lowmask(b_len));
    step();
    tx_valid = 1'b0;
  endtask

  task automatic run_xchg(input string tag);
    edges = 0; ss_offs = 0; nb = 0; acc = '0; mon_on = 1;
    wr(cfgword(1'b1, 1'b1));
    chk(busy == 1'b1, {tag, " R3 busy after go"}, busy, 1);
    while (busy) step();
    repeat (2) step();
    mon_on = 0;
  endtask

  // serial monitor: decodes mosi at the sampling edge
  always @(sclk) begin
    #1;
    if (mon_on) begin
      edges++;
      if (edges == 1) t_prev = $time;
      else if (edges == 2) gap = $time - t_prev;
      if ((b_cpha == 1'b0) ? (sclk != b_cpol) : (sclk == b_cpol)) begin
        acc = {acc[14:0], mosi};
        nb++;
        if (nb == int'(b_len) + 1) begin
          if (mosi_q.size() == 0) chk(0, "R5 unexpected serial word", acc, 0);
          else begin
            logic [15:0] e;
            e = mosi_q.pop_front();
            chk(acc == e, "R5 serial word", acc, e);
          end
          nb = 0;
          acc = '0;
        end
      end
    end
  end

  always @(ss) if (mon_on && ss != b_spol) ss_offs++;

  // receive scoreboard
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (rx_q.size() == 0) chk(0, "R6 unexpected rx word", rx_data, 0);
      else begin
        logic [15:0] e;
        e = rx_q.pop_front();
        chk(rx_data == e, "R6 rx word", rx_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    chk(busy == 0, "R3 reset busy", busy, 0);
    chk(tx_ready == 1, "R12 reset tx_ready", tx_ready, 1);
    chk(rx_valid == 0, "R6 reset rx_valid", rx_valid, 0);
    chk(ss == 1, "R7 reset ss inactive low-active", ss, 1);
    chk(sclk == 0, "R9 reset sclk", sclk, 0);

    // enable with go in the same write does not start
    b_len = 4'd7;
    begin
      logic [13:0] v;
      v = cfgword(1'b1, 1'b1);
      push(16'h0055, 0, 0);
      wr(v);
      step();
      chk(busy == 0, "R3 go ignored while enabling", busy, 0);
      wr(cfgword(1'b0, 1'b0));
    end

    // mode 0, 8-bit, continuous select, fastest clock
    mode(0, 0, 0, 0, 0, 4'd7, 3'd0);
    push(16'h00A5, 1, 1);
    push(16'h003C, 1, 1);
    push(16'h01FF, 1, 1);
    run_xchg("T1");
    chk(ss_offs == 1, "R8 continuous select", ss_offs, 1);
    chk(gap == 8, "R10 half period k=0", gap, 8);
    chk(sclk == 0, "R9 idle low", sclk, 0);
    chk(ss == 1, "R7 idle active-low", ss, 1);
    chk(mosi_q.size() == 0, "R4 all words sent", mosi_q.size(), 0);
    repeat (4) step();
    chk(rx_q.size() == 0, "R6 all words received", rx_q.size(), 0);

    // locked fields
    begin
      logic [13:0] old;
      old = cfg_rdata;
      wr(cfgword(1'b1, 1'b0) ^ 14'h03E4);
      chk(cfg_rdata == old, "R2 fields locked", cfg_rdata, old);
      chk(busy == 0, "R2 no start", busy, 0);
    end

    // phase 1, idle high, active-high select, 16 bits, pulse, k=2
    mode(1, 1, 1, 1, 0, 4'd15, 3'd2);
    push(16'hBEEF, 1, 1);
    push(16'h8001, 1, 1);
    push(16'h1234, 1, 1);
    run_xchg("T2");
    chk(ss_offs == 3, "R8 pulsed select", ss_offs, 3);
    chk(gap == 32, "R10 half period k=2", gap, 32);
    chk(sclk == 1, "R9 idle high", sclk, 1);
    chk(ss == 0, "R7 idle active-high", ss, 0);
    repeat (4) step();
    chk(rx_q.size() == 0, "R6 16-bit words received", rx_q.size(), 0);

    // 1-bit words, phase 0 idle high
    mode(0, 0, 0, 1, 0, 4'd0, 3'd1);
    push(16'h0001, 1, 1);
    push(16'h0000, 1, 1);
    push(16'hFFFE, 1, 1);
    run_xchg("T3");
    chk(mosi_q.size() == 0, "R5 1-bit words", mosi_q.size(), 0);
    repeat (4) step();
    chk(rx_q.size() == 0, "R6 1-bit words received", rx_q.size(), 0);

    // ready gate holds the word
    mode(0, 0, 1, 0, 1, 4'd11, 3'd0);
    push(16'h0ABC, 1, 1);
    edges = 0; nb = 0; acc = '0; mon_on = 1;
    wr(cfgword(1'b1, 1'b1));
    repeat (40) step();
    chk(busy == 1, "R11 busy while held", busy, 1);
    chk(edges == 0, "R11 no clock while held", edges, 0);
    chk(ss == 1, "R11 select inactive while held", ss, 1);
    rdy_n = 1'b0;
    while (busy) step();
    repeat (2) step();
    mon_on = 0;
    rdy_n = 1'b1;
    chk(mosi_q.size() == 0, "R11 word sent after ready", mosi_q.size(), 0);
    repeat (4) step();
    chk(rx_q.size() == 0, "R11 word received", rx_q.size(), 0);

    // receive queue overflow drops words
    mode(0, 0, 0, 0, 0, 4'd3, 3'd0);
    rx_ready = 1'b0;
    for (int i = 0; i < 8; i++) push(16'(16'hF0 + i), 1, 1);
    chk(tx_ready == 0, "R12 tx full", tx_ready, 0);
    edges = 0; nb = 0; acc = '0; mon_on = 1;
    wr(cfgword(1'b1, 1'b1));
    push(16'h0009, 1, 0);
    push(16'h000A, 1, 0);
    while (busy) step();
    repeat (2) step();
    mon_on = 0;
    chk(rx_valid == 1, "R6 rx holds words", rx_valid, 1);
    begin
      logic [15:0] h;
      h = rx_data;
      repeat (3) step();
      chk(rx_data == h, "R12 rx_data stable under stall", rx_data, h);
    end
    rx_ready = 1'b1;
    repeat (12) step();
    chk(rx_q.size() == 0, "R6 first eight delivered", rx_q.size(), 0);
    chk(rx_valid == 0, "R6 extra words dropped", rx_valid, 0);

    // disable flushes both queues
    mode(0, 0, 0, 0, 0, 4'd7, 3'd0);
    rx_ready = 1'b0;
    push(16'h0011, 1, 1);
    push(16'h0022, 1, 1);
    run_xchg("T6");
    for (int i = 0; i < 8; i++) push(16'(i), 0, 0);
    chk(tx_ready == 0, "R12 tx full before flush", tx_ready, 0);
    wr(cfgword(1'b0, 1'b0));
    rx_q.delete();
    chk(tx_ready == 1, "R1 tx emptied", tx_ready, 1);
    chk(rx_valid == 0, "R1 rx emptied", rx_valid, 0);
    chk(busy == 0, "R1 not busy", busy, 0);
    rx_ready = 1'b1;
    wr(cfgword(1'b1, 1'b0));
    edges = 0; mon_on = 1;
    wr(cfgword(1'b1, 1'b1));
    repeat (3) step();
    chk(busy == 0, "R4 empty queue clears busy", busy, 0);
    chk(edges == 0, "R4 no clock on empty queue", edges, 0);
    mon_on = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule